// File: doc/BRIEF.md
# Two-Road Crossing Signal Controller

This block sequences the signals at a crossing of two roads, called north-south (road A) and east-west (road B). A vehicle sensor on each road reports whether traffic is waiting or passing. The controller is a Moore machine with four phases: road A green, road A amber, road B green and road B amber. A road keeps its green for as long as its own sensor reports traffic. When that sensor goes quiet, the road gets one amber cycle and then the right of way passes to the other road.

The light outputs are decoded directly from two state bits. Each road has a 2-bit light code, so the outputs change only on a clock edge and never glitch on a sensor input. A synchronous, active-high reset puts the crossing in the road-A-green phase.

Top module: `xing_signal_ctrl`

## Requirements
- R1: On the first clock edge with `rst` high, the state becomes 2'b00 and the lights become `light_a`=2'b00 (green) and `light_b`=2'b10 (red). The light codes are green=2'b00, amber=2'b01 and red=2'b10.
- R2: In state 2'b00, the machine stays in 2'b00 after an edge where `sense_a` is 1. After an edge where `sense_a` is 0, it moves to 2'b01.
- R3: State 2'b01 always moves to 2'b10 on the next edge, whatever the sensors show.
- R4: In state 2'b10, the machine stays in 2'b10 after an edge where `sense_b` is 1. After an edge where `sense_b` is 0, it moves to 2'b11.
- R5: State 2'b11 always moves to 2'b00 on the next edge, whatever the sensors show.
- R6: The lights per state are as follows: 00 gives A=green, B=red; 01 gives A=amber, B=red; 10 gives A=red, B=green; 11 gives A=red, B=amber. `state` carries the present state with bit 1 as the high bit.
- R7: `sense_b` has no effect while in state 2'b00, and `sense_a` has no effect while in state 2'b10.
- R8: The code 2'b11 never appears on either light output.
- R9: At least one road shows red in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sense_a | input | 1 | Traffic present on road A |
| sense_b | input | 1 | Traffic present on road B |
| light_a | output | 2 | Road A light code |
| light_b | output | 2 | Road B light code |
| state | output | 2 | Present phase of the machine |

## Verification
The bench holds each sensor high for long stretches to confirm that green is held. It raises the opposing sensor during a green phase; a design that mixed up the sensors would leave green early or hold it on the wrong road. It also drives sensors during the amber phases, where a design that gated amber on a sensor would stall in amber. Random sensor patterns are compared every cycle against a table model, which catches a wrong light decode or a case where both roads are non-red.

// File: rtl/xing_pkg.sv
package xing_pkg;
    localparam int ST_W  = 2;
    localparam int LGT_W = 2;

    typedef enum logic [ST_W-1:0] {
        PH_A_GO   = 2'b00,
        PH_A_WARN = 2'b01,
        PH_B_GO   = 2'b10,
        PH_B_WARN = 2'b11
    } phase_t;

    localparam logic [LGT_W-1:0] LGT_GREEN = 2'b00;
    localparam logic [LGT_W-1:0] LGT_AMBER = 2'b01;
    localparam logic [LGT_W-1:0] LGT_RED   = 2'b10;

    typedef struct packed {
        logic [ST_W-1:0] ph;
    } ctrl_regs_t;
endpackage

// File: rtl/xing_next_phase.sv
module xing_next_phase
    import xing_pkg::*;
(
    input  logic [ST_W-1:0] cur,
    input  logic            sense_a,
    input  logic            sense_b,
    output logic [ST_W-1:0] nxt
);
    logic hold;

    always_comb begin
        // Only the green phases (low bit 0) can hold; the high bit picks the road's sensor.
        hold   = ~cur[0] & (cur[1] ? sense_b : sense_a);
        nxt[1] = cur[1] ^ cur[0];
        nxt[0] = ~cur[0] & ~hold;
    end
endmodule

// File: rtl/xing_light_decode.sv
module xing_light_decode
    import xing_pkg::*;
(
    input  logic [ST_W-1:0]  cur,
    output logic [LGT_W-1:0] light_a,
    output logic [LGT_W-1:0] light_b
);
    always_comb begin
        light_a = {cur[1], ~cur[1] & cur[0]};
        light_b = {~cur[1], cur[1] & cur[0]};
    end
endmodule

// File: rtl/xing_signal_ctrl.sv
module xing_signal_ctrl
    import xing_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sense_a,
    input  logic             sense_b,
    output logic [LGT_W-1:0] light_a,
    output logic [LGT_W-1:0] light_b,
    output logic [ST_W-1:0]  state
);
    ctrl_regs_t      regs_d, regs_q;
    logic [ST_W-1:0] nxt_ph;

    xing_next_phase u_next (
        .cur     (regs_q.ph),
        .sense_a (sense_a),
        .sense_b (sense_b),
        .nxt     (nxt_ph)
    );

    xing_light_decode u_dec (
        .cur     (regs_q.ph),
        .light_a (light_a),
        .light_b (light_b)
    );

    always_comb begin
        regs_d    = regs_q;
        regs_d.ph = rst ? PH_A_GO : nxt_ph;
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign state = regs_q.ph;

    a_r1_reset_a_green: assert property (@(posedge clk)
        rst |=> (state == 2'b00 && light_a == LGT_GREEN && light_b == LGT_RED));
    a_r2_a_hold: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b00 && sense_a) |=> state == 2'b00);
    a_r2_a_release: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b00 && !sense_a) |=> state == 2'b01);
    a_r3_a_warn_passes: assert property (@(posedge clk) disable iff (rst)
        state == 2'b01 |=> state == 2'b10);
    a_r4_b_hold: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b10 && sense_b) |=> state == 2'b10);
    a_r4_b_release: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b10 && !sense_b) |=> state == 2'b11);
    a_r5_b_warn_passes: assert property (@(posedge clk) disable iff (rst)
        state == 2'b11 |=> state == 2'b00);
    a_r8_no_code3: assert property (@(posedge clk) disable iff (rst)
        light_a != 2'b11 && light_b != 2'b11);
    a_r9_one_red: assert property (@(posedge clk) disable iff (rst)
        light_a == LGT_RED || light_b == LGT_RED);
endmodule

// File: tb/xing_signal_ctrl_test.sv
module xing_signal_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sense_a = 1'b0;
    logic       sense_b = 1'b0;
    logic [1:0] light_a, light_b, state;

    int total = 0;
    int bad   = 0;
    int model = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    xing_signal_ctrl uut (
        .clk(clk), .rst(rst), .sense_a(sense_a), .sense_b(sense_b),
        .light_a(light_a), .light_b(light_b), .state(state)
    );

    function automatic int next_of(int s, bit ra, bit sa, bit sb);
        if (ra) return 0;
        case (s)
            0: return sa ? 0 : 1;
            1: return 2;
            2: return sb ? 2 : 3;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        int ea, eb;
        case (model)
            0: begin ea = 0; eb = 2; end
            1: begin ea = 1; eb = 2; end
            2: begin ea = 2; eb = 0; end
            default: begin ea = 2; eb = 1; end
        endcase
        chk("R2/R3/R4/R5 state", state, model);
        chk("R6 light_a", light_a, ea);
        chk("R6 light_b", light_b, eb);
        chk("R8 no code 3", (light_a == 3 || light_b == 3) ? 1 : 0, 0);
        chk("R9 a red present", (light_a == 2 || light_b == 2) ? 1 : 0, 1);
    endtask

    // Drive inputs at the falling edge; compare after the rising edge.
    task automatic step(input bit ra, input bit sa, input bit sb);
        @(negedge clk);
        rst = ra; sense_a = sa; sense_b = sb;
        @(posedge clk);
        model = next_of(model, ra, sa, sb);
        #1;
        compare_all();
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(1, 0, 0);
        chk("R1 reset state", state, 0);
        chk("R1 reset light_a", light_a, 0);
        chk("R1 reset light_b", light_b, 2);
        // R2 hold A green; R7 sense_b ignored in state 00
        for (int i = 0; i < 6; i++) step(0, 1, i[0]);
        chk("R7 still A green", state, 0);
        step(0, 0, 1);   // -> 01
        step(0, 1, 1);   // R3 amber passes despite sensors -> 10
        chk("R3 amber to B green", state, 2);
        // R4 hold B green; R7 sense_a ignored in state 10
        for (int i = 0; i < 6; i++) step(0, i[0], 1);
        chk("R7 still B green", state, 2);
        step(0, 1, 0);   // -> 11
        step(0, 1, 1);   // R5 -> 00
        chk("R5 wrap to A green", state, 0);
        // reset in the middle of the cycle
        step(0, 0, 0); step(0, 0, 0);
        step(1, 1, 1);
        chk("R1 reset mid cycle", state, 0);
        // random patterns
        for (int i = 0; i < 2000; i++) step(0, 1'($urandom), 1'($urandom));
        // all quiet: the phases cycle freely
        for (int i = 0; i < 8; i++) step(0, 0, 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule